// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

The translator sits between a bus requester and a memory port. Every 32-bit word of a 32 MiB alias window stands for a single bit of real memory. A read of an alias word fetches the underlying bytes and returns the chosen bit, zero-extended, as 0 or 1. A write of an alias word becomes a locked read-modify-write of the underlying bytes. It changes only that bit to the value of bit 0 of the write data.

Both ports use a valid/ready handshake. A request carries the window offset, an access size, a write flag and write data. It is answered by exactly one response carrying read data and an error flag. Only one request is in flight at a time. The `BASE_ADDR` parameter places the real memory, so separate instances can serve separate regions, for example an SRAM region at 0x2000_0000 and a peripheral region at 0x4000_0000.

Top module: `bb_alias_xlate`

## Requirements
- R1: The memory address is `BASE_ADDR | (offset >> 5)`, rounded down to a multiple of the access size, where `offset` is the 25-bit window offset.
- R2: Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The memory access uses the same code. Code 3 gives a response with error 1 and read data 0, and issues no memory access.
- R3: The target bit position is `(offset >> 2) & (8*bytes - 1)`. Memory data is right-justified in little-endian order, with byte 0 at bits 7:0, so the target bit is data bit `position`.
- R4: A read issues one memory read with the write flag at 0. It returns the target bit in read-data bit 0, and every other read-data bit is 0.
- R5: A write issues a memory read and then a memory write to the same address and size. The write data equals the fetched data with only the target bit replaced by bit 0 of the request write data. The other request data bits are ignored. Memory write-data bits above 8*bytes are 0.
- R6: An error on the memory read ends the access with error 1 and read data 0, and no memory write is issued. An error on the write-back ends the access with error 1.
- R7: For a write, the lock output is 1 on both the read and the write memory requests. For a read, the lock output is 0.
- R8: The slave port is ready only when no response is pending. A pending response and a pending memory request each hold their values until the other side accepts them.
- R9: While reset is active, the slave port is ready and no response, memory request or lock is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req_valid | input | 1 | Request valid |
| s_req_ready | output | 1 | Request accepted when high with valid |
| s_req_offset | input | WIN_W | Byte offset inside the alias window |
| s_req_size | input | 2 | Access size code |
| s_req_write | input | 1 | 1 for write, 0 for read |
| s_req_wdata | input | DATA_W | Write data, bit 0 is the bit value |
| s_rsp_valid | output | 1 | Response valid |
| s_rsp_ready | input | 1 | Response accepted |
| s_rsp_rdata | output | DATA_W | Read data, target bit in bit 0 |
| s_rsp_err | output | 1 | Access ended in error |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request accepted |
| m_req_addr | output | ADDR_W | Aligned memory byte address |
| m_req_size | output | 2 | Memory access size code |
| m_req_write | output | 1 | Memory write when high |
| m_req_wdata | output | DATA_W | Right-justified memory write data |
| m_req_lock | output | 1 | Held across both phases of a read-modify-write |
| m_rsp_valid | input | 1 | Memory response valid |
| m_rsp_rdata | input | DATA_W | Right-justified memory read data |
| m_rsp_err | input | 1 | Memory response error |

## Verification
Eight alias words of one byte are read bit by bit. The same physical bit is then read through all three sizes, which separates address rounding from bit-position masking. Writes that set a bit and writes that clear one are sent with junk in the upper data bits, at each size, including the last word of the window. Each is checked by reading back through the alias and by comparing the bench memory against its model, so a change to a neighbouring bit is caught. Errors are injected on the fetch of a read, on the fetch of a write and on the write-back, and an illegal size code is sent. These tell the abort paths apart by the memory-request counts and by the lock seen on each request.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  localparam logic [1:0] SZ_B1 = 2'd0;
  localparam logic [1:0] SZ_B2 = 2'd1;
  localparam logic [1:0] SZ_B4 = 2'd2;

  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 25,
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic [WIN_W-1:0]  offset,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr,
  output logic [POS_W-1:0]  bitpos,
  output logic              legal
);
  import bb_pkg::*;
  // one alias word (4 bytes) per bit: 2 bits of word offset + 3 bits of bit-in-byte
  localparam int SHIFT = 2 + $clog2(8);

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] lane_lo;
  logic [POS_W-1:0]  pos_mask;

  assign raw = BASE_ADDR | ADDR_W'(offset >> SHIFT);

  always_comb begin
    legal    = 1'b1;
    lane_lo  = '0;
    pos_mask = POS_W'(7);
    case (size)
      SZ_B1: begin lane_lo = ADDR_W'(0); pos_mask = POS_W'(7);  end
      SZ_B2: begin lane_lo = ADDR_W'(1); pos_mask = POS_W'(15); end
      SZ_B4: begin lane_lo = ADDR_W'(3); pos_mask = POS_W'(31); end
      default: legal = 1'b0;
    endcase
  end

  assign addr   = raw & ~lane_lo;
  assign bitpos = POS_W'(offset >> 2) & pos_mask;
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [POS_W-1:0]  bitpos,
  input  logic [1:0]        size,
  input  logic              bit_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] wb_data
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] smask;
  logic [DATA_W-1:0] sel;
  logic [3:0]        nbytes;

  assign nbytes = 4'd1 << size;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign smask[g*8 +: 8] = {8{(g < int'(nbytes))}};
  end

  assign sel     = DATA_W'(1) << bitpos;
  assign bit_out = |(rdata & sel);
  assign wb_data = ((rdata & smask) & ~sel) | (bit_val ? sel : '0);
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic [1:0]        s_req_size,
  input  logic              s_req_write,
  input  logic              s_req_bit,
  output logic              s_rsp_valid,
  input  logic              s_rsp_ready,
  output logic [DATA_W-1:0] s_rsp_rdata,
  output logic              s_rsp_err,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [POS_W-1:0]  map_pos,
  input  logic              map_legal,
  output logic [POS_W-1:0]  q_pos,
  output logic              q_bit,
  input  logic              lane_bit,
  input  logic [DATA_W-1:0] lane_wb,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [1:0]        m_req_size,
  output logic              m_req_write,
  output logic [DATA_W-1:0] m_req_wdata,
  output logic              m_req_lock,
  input  logic              m_rsp_valid,
  input  logic              m_rsp_err
);
  bb_state_e state;
  logic      q_wr;

  assign s_req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      q_wr        <= 1'b0;
      q_pos       <= '0;
      q_bit       <= 1'b0;
      s_rsp_valid <= 1'b0;
      s_rsp_rdata <= '0;
      s_rsp_err   <= 1'b0;
      m_req_valid <= 1'b0;
      m_req_addr  <= '0;
      m_req_size  <= SZ_B1;
      m_req_write <= 1'b0;
      m_req_wdata <= '0;
      m_req_lock  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (s_req_valid) begin
          q_wr  <= s_req_write;
          q_pos <= map_pos;
          q_bit <= s_req_bit;
          if (!map_legal) begin
            s_rsp_valid <= 1'b1;
            s_rsp_err   <= 1'b1;
            s_rsp_rdata <= '0;
            state       <= ST_RESP;
          end else begin
            m_req_valid <= 1'b1;
            m_req_write <= 1'b0;
            m_req_addr  <= map_addr;
            m_req_size  <= s_req_size;
            m_req_wdata <= '0;
            m_req_lock  <= s_req_write;
            state       <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (m_req_ready) begin
          m_req_valid <= 1'b0;
          state       <= ST_RD_WAIT;
        end
        ST_RD_WAIT: if (m_rsp_valid) begin
          if (m_rsp_err || !q_wr) begin
            m_req_lock  <= 1'b0;
            s_rsp_valid <= 1'b1;
            s_rsp_err   <= m_rsp_err;
            s_rsp_rdata <= m_rsp_err ? '0 : DATA_W'(lane_bit);
            state       <= ST_RESP;
          end else begin
            m_req_valid <= 1'b1;
            m_req_write <= 1'b1;
            m_req_wdata <= lane_wb;
            state       <= ST_WR_REQ;
          end
        end
        ST_WR_REQ: if (m_req_ready) begin
          m_req_valid <= 1'b0;
          state       <= ST_WR_WAIT;
        end
        ST_WR_WAIT: if (m_rsp_valid) begin
          m_req_lock  <= 1'b0;
          m_req_write <= 1'b0;
          s_rsp_valid <= 1'b1;
          s_rsp_err   <= m_rsp_err;
          s_rsp_rdata <= '0;
          state       <= ST_RESP;
        end
        ST_RESP: if (s_rsp_ready) begin
          s_rsp_valid <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: both phases of a read-modify-write carry the lock
  a_r7_lock_on_write: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && m_req_write |-> m_req_lock);
  a_r7_lock_kept: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && !m_req_write && m_req_lock && m_req_ready |=> m_req_lock);
  // R8: handshakes hold their payload
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata));
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid && !s_rsp_ready |=> s_rsp_valid && $stable(s_rsp_rdata) && $stable(s_rsp_err));
  a_r8_busy: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> !s_req_ready);
  // R1: memory address is aligned to the access size
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> ((m_req_size == SZ_B4) ? (m_req_addr[1:0] == 2'b00) :
                     (m_req_size == SZ_B2) ? (m_req_addr[0] == 1'b0) : 1'b1));
  // R2: only legal sizes reach memory
  a_r2_size_legal: assert property (@(posedge clk) disable iff (rst)
    m_req_valid |-> m_req_size != 2'd3);
  // R4: read data carries a single bit
  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> s_rsp_rdata[DATA_W-1:1] == '0);
  // R5: byte write-back leaves upper lanes zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && m_req_write && m_req_size == SZ_B1 |-> m_req_wdata[DATA_W-1:8] == '0);
endmodule

// File: rtl/bb_alias_xlate.sv
module bb_alias_xlate #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 25,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic [WIN_W-1:0]  s_req_offset,
  input  logic [1:0]        s_req_size,
  input  logic              s_req_write,
  input  logic [DATA_W-1:0] s_req_wdata,
  output logic              s_rsp_valid,
  input  logic              s_rsp_ready,
  output logic [DATA_W-1:0] s_rsp_rdata,
  output logic              s_rsp_err,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [1:0]        m_req_size,
  output logic              m_req_write,
  output logic [DATA_W-1:0] m_req_wdata,
  output logic              m_req_lock,
  input  logic              m_rsp_valid,
  input  logic [DATA_W-1:0] m_rsp_rdata,
  input  logic              m_rsp_err
);
  localparam int POS_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] map_addr;
  logic [POS_W-1:0]  map_pos;
  logic              map_legal;
  logic [POS_W-1:0]  q_pos;
  logic              q_bit;
  logic              lane_bit;
  logic [DATA_W-1:0] lane_wb;
  logic              unused_wdata;

  assign unused_wdata = ^s_req_wdata[DATA_W-1:1];

  bb_addr_map #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .POS_W(POS_W), .BASE_ADDR(BASE_ADDR)
  ) u_map (
    .offset(s_req_offset), .size(s_req_size),
    .addr(map_addr), .bitpos(map_pos), .legal(map_legal)
  );

  bb_bit_lane #(.DATA_W(DATA_W), .POS_W(POS_W)) u_lane (
    .rdata(m_rsp_rdata), .bitpos(q_pos), .size(m_req_size), .bit_val(q_bit),
    .bit_out(lane_bit), .wb_data(lane_wb)
  );

  bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
    .s_req_size(s_req_size), .s_req_write(s_req_write), .s_req_bit(s_req_wdata[0]),
    .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
    .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err),
    .map_addr(map_addr), .map_pos(map_pos), .map_legal(map_legal),
    .q_pos(q_pos), .q_bit(q_bit),
    .lane_bit(lane_bit), .lane_wb(lane_wb),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_size(m_req_size), .m_req_write(m_req_write), .m_req_wdata(m_req_wdata),
    .m_req_lock(m_req_lock), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err)
  );
endmodule

// File: tb/bb_alias_xlate_tb.sv
`timescale 1ns/1ps
module bb_alias_xlate_tb;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        s_req_valid = 0, s_req_write = 0, s_rsp_ready = 0;
  logic [24:0] s_req_offset = '0;
  logic [1:0]  s_req_size = '0;
  logic [31:0] s_req_wdata = '0;
  logic        s_req_ready, s_rsp_valid, s_rsp_err;
  logic [31:0] s_rsp_rdata;
  logic        m_req_valid, m_req_write, m_req_lock;
  logic [31:0] m_req_addr, m_req_wdata;
  logic [1:0]  m_req_size;
  logic        m_req_ready = 0, m_rsp_valid = 0, m_rsp_err = 0;
  logic [31:0] m_rsp_rdata = '0;

  bb_alias_xlate #(.BASE_ADDR(BASE)) u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench memory and its independent model
  logic [7:0] mem [logic [31:0]];
  logic [7:0] em  [logic [31:0]];
  function automatic logic [7:0] dflt(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic logic [7:0] rd_em(input logic [31:0] a);
    return em.exists(a) ? em[a] : dflt(a);
  endfunction

  // globals shared between driver and memory responder
  bit          cur_wr = 0, inj_rd = 0, inj_wr = 0;
  logic [31:0] exp_maddr = '0;
  logic [1:0]  exp_msize = '0;
  int          m_rd_cnt = 0, m_wr_cnt = 0;

  // memory responder
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] pdata = '0;
    bit perr = 0;
    forever begin
      @(negedge clk);
      m_rsp_valid = 0;
      m_req_ready = 0;
      if (pend) begin
        if (dly == 0) begin
          m_rsp_valid = 1; m_rsp_rdata = pdata; m_rsp_err = perr; pend = 0;
        end else dly--;
      end else if (m_req_valid && (cyc % 3 != 0)) begin
        int nb;
        m_req_ready = 1;
        nb = 1 << m_req_size;
        chk(m_req_addr == exp_maddr, "R1", "memory address", m_req_addr, exp_maddr);
        chk(m_req_size == exp_msize, "R2", "memory size", 32'(m_req_size), 32'(exp_msize));
        pdata = '0;
        if (!m_req_write) begin
          m_rd_cnt++;
          chk(m_req_lock == cur_wr, "R7", "lock on fetch", 32'(m_req_lock), 32'(cur_wr));
          for (int i = 0; i < nb; i++) pdata[i*8 +: 8] = rd_mem(m_req_addr + i);
          perr = inj_rd;
        end else begin
          m_wr_cnt++;
          chk(m_req_lock == 1'b1, "R7", "lock on write-back", 32'(m_req_lock), 32'd1);
          chk((nb == 4) || ((m_req_wdata >> (nb*8)) == 0), "R5", "upper write lanes",
              m_req_wdata, m_req_wdata & ((32'd1 << (nb*8)) - 1));
          if (!inj_wr) for (int i = 0; i < nb; i++) mem[m_req_addr + i] = m_req_wdata[i*8 +: 8];
          perr = inj_wr;
        end
        pend = 1;
        dly = cyc % 2;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] rdata;
    bit          err;
    string       req;
  } exp_t;
  exp_t sbq[$];
  int rsp_cnt = 0;

  initial begin
    bit held = 0;
    logic [31:0] hd = '0;
    bit he = 0;
    forever begin
      bit r;
      @(negedge clk);
      if (rst) continue;
      if (s_rsp_valid) chk(!s_req_ready, "R8", "ready while response pending", 32'(s_req_ready), 0);
      if (held) chk(s_rsp_valid && s_rsp_rdata == hd && s_rsp_err == he, "R8",
                    "stalled response held", s_rsp_rdata, hd);
      r = (cyc % 4 != 1);
      s_rsp_ready = r;
      held = 0;
      if (s_rsp_valid && r) begin
        exp_t e;
        if (sbq.size() == 0) chk(0, "R8", "unexpected response", s_rsp_rdata, 0);
        else begin
          e = sbq.pop_front();
          chk(s_rsp_rdata == e.rdata, e.req, "read data", s_rsp_rdata, e.rdata);
          chk(s_rsp_err == e.err, e.req, "error flag", 32'(s_rsp_err), 32'(e.err));
        end
        rsp_cnt++;
      end else if (s_rsp_valid) begin
        held = 1; hd = s_rsp_rdata; he = s_rsp_err;
      end
    end
  end

  int issued = 0;
  task automatic access(input logic [24:0] off, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input bit erd, input bit ewr, input string req);
    exp_t e;
    int nb, pos, rd0, wr0, exp_rd, exp_wr;
    logic [31:0] a, ba;
    bit legal;
    legal = (sz != 2'd3);
    nb  = legal ? (1 << sz) : 1;
    a   = (BASE | (32'(off) >> 5)) & ~(32'(nb) - 1);
    pos = (int'(off) >> 2) & (nb*8 - 1);
    ba  = a + 32'(pos >> 3);
    e.req = req;
    e.err = !legal || erd || (wr && ewr);
    e.rdata = (legal && !wr && !erd) ? 32'(rd_em(ba)[pos & 7]) : 32'd0;
    if (legal && wr && !erd && !ewr) begin
      logic [7:0] b;
      b = rd_em(ba);
      b[pos & 7] = wd[0];
      em[ba] = b;
    end
    exp_rd = legal ? 1 : 0;
    exp_wr = (legal && wr && !erd) ? 1 : 0;
    sbq.push_back(e);
    cur_wr = wr; inj_rd = erd; inj_wr = ewr;
    exp_maddr = a; exp_msize = sz;
    rd0 = m_rd_cnt; wr0 = m_wr_cnt;
    @(negedge clk);
    s_req_valid = 1; s_req_offset = off; s_req_size = sz; s_req_write = wr; s_req_wdata = wd;
    while (!s_req_ready) @(negedge clk);
    @(negedge clk);
    s_req_valid = 0;
    issued++;
    while (rsp_cnt != issued) @(negedge clk);
    chk(m_rd_cnt - rd0 == exp_rd, req, "memory reads", 32'(m_rd_cnt - rd0), 32'(exp_rd));
    chk(m_wr_cnt - wr0 == exp_wr, req, "memory writes", 32'(m_wr_cnt - wr0), 32'(exp_wr));
    if (legal) for (int i = 0; i < nb; i++)
      chk(rd_mem(a + i) == rd_em(a + i), req, "memory byte", 32'(rd_mem(a + i)), 32'(rd_em(a + i)));
  endtask

  function automatic logic [24:0] aoff(input int byte_ofs, input int bitn);
    return 25'((byte_ofs << 5) | (bitn << 2));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    chk(0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(s_req_ready == 1, "R9", "ready in reset", 32'(s_req_ready), 1);
    chk(s_rsp_valid == 0, "R9", "response in reset", 32'(s_rsp_valid), 0);
    chk(m_req_valid == 0, "R9", "memory request in reset", 32'(m_req_valid), 0);
    chk(m_req_lock == 0, "R9", "lock in reset", 32'(m_req_lock), 0);
    rst = 0;
    // R4 and R3: every bit of one byte
    for (int b = 0; b < 8; b++) access(aoff(32'h123, b), 2'd0, 0, 0, 0, 0, "R4");
    // R1 and R3: one physical bit through all three sizes
    access(aoff(32'h123, 5), 2'd1, 0, 0, 0, 0, "R3");
    access(aoff(32'h123, 5), 2'd2, 0, 0, 0, 0, "R1");
    access(aoff(32'h456, 2), 2'd2, 0, 0, 0, 0, "R3");
    // R5: set and clear with junk in the other data bits
    access(aoff(32'h200, 3), 2'd2, 1, 32'hFFFF_FFF1, 0, 0, "R5");
    access(aoff(32'h200, 3), 2'd0, 0, 0, 0, 0, "R5");
    access(aoff(32'h201, 7), 2'd1, 1, 32'hFFFF_FFFE, 0, 0, "R5");
    access(aoff(32'h201, 7), 2'd2, 0, 0, 0, 0, "R5");
    access(aoff(32'h202, 0), 2'd0, 1, 32'h0000_0003, 0, 0, "R5");
    access(aoff(32'h202, 0), 2'd0, 1, 32'hFFFF_FFFE, 0, 0, "R5");
    access(aoff(32'h202, 0), 2'd1, 0, 0, 0, 0, "R5");
    // R1: last word of the window
    access(25'h1FF_FFFC, 2'd2, 0, 0, 0, 0, "R1");
    access(25'h1FF_FFFC, 2'd2, 1, 32'h0000_0000, 0, 0, "R1");
    access(25'h1FF_FFFC, 2'd0, 0, 0, 0, 0, "R1");
    // R2: illegal size code
    access(aoff(32'h300, 1), 2'd3, 0, 0, 0, 0, "R2");
    access(aoff(32'h300, 1), 2'd3, 1, 1, 0, 0, "R2");
    // R6: error on fetch and on write-back
    access(aoff(32'h310, 4), 2'd2, 0, 0, 1, 0, "R6");
    access(aoff(32'h311, 4), 2'd1, 1, 1, 1, 0, "R6");
    access(aoff(32'h312, 6), 2'd0, 1, 1, 0, 1, "R6");
    access(aoff(32'h312, 6), 2'd0, 0, 0, 0, 0, "R6");
    // R7: plain read after writes carries no lock (checked in responder)
    access(aoff(32'h2, 1), 2'd2, 0, 0, 0, 0, "R7");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule